// File: doc/BRIEF.md
# Address Phase Parity Unit

This block guards the address phase of a split-transaction system bus whose address, parity and error lines are all active low. As the request initiator it produces two address parity bits from the outgoing address lines in the same cycle, so that they can go out together with the strobe and the address. As a bus observer it checks the address that is present in every cycle where the active-low strobe is asserted. On a mismatch it pulls the shared active-low error line low for one cycle.

The address field runs from bit 35 down to bit 3, which spans a 2^36-byte space. It is split into two parity groups. The lower parity bit covers bits 23..3 and the upper bit covers bits 35..24. A parity line is correct when it is high for an even number of low covered lines. While reset is asserted, a configuration strap is sampled. Its value at the last clock edge before reset is released decides whether a new assertion of the observed error line aborts the current transaction. When the strap disables this, the error line is left to a central agent and the abort output stays low.

Top module: `abp_unit`

## Requirements
- R1: Bit 1 of `init_ap_n` covers `init_addr_n[35:24]`. It is high exactly when an even number of those lines are low, so an all-high address gives 1 and an all-low address also gives 1. It follows the address in the same cycle.
- R2: Bit 0 of `init_ap_n` covers `init_addr_n[23:3]` under the same rule. An all-high address gives 1 and an all-low address gives 0. It follows the address in the same cycle.
- R3: In a cycle k where `bus_ads_n` is low and `bus_ap_n` differs from the parity that R1/R2 define for `bus_addr_n`, `aerr_drive_n` is low in cycle k+2 only.
- R4: When `bus_ads_n` is high, no parity error is raised, whatever the address and parity lines carry.
- R5: `aerr_drive_n` is high in every cycle not selected by R3, including while reset is asserted.
- R6: The abort enable is the value of `cfg_abort_en` at the last clock edge while `rst_n` is low. Changes to the strap after reset release have no effect until the next reset.
- R7: With the enable set, a high-to-low transition of `aerr_obs_n` between cycle k-1 and cycle k makes `xact_abort` high for cycle k+1 only. This holds whichever agent drives the line.
- R8: With the enable clear, `xact_abort` stays low regardless of `aerr_obs_n`.
- R9: An error line held low for several cycles, including back-to-back errors, yields exactly one abort pulse. `xact_abort` is low while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset; the strap is sampled while it is low |
| cfg_abort_en | input | 1 | Power-on strap: 1 lets an observed error abort the transaction |
| init_addr_n | input | 33 | Outgoing active-low address lines [35:3] as initiator |
| init_ap_n | output | 2 | Generated active-low parity, bit 1 upper group, bit 0 lower group |
| bus_ads_n | input | 1 | Observed active-low address strobe |
| bus_addr_n | input | 33 | Observed active-low address lines [35:3] |
| bus_ap_n | input | 2 | Observed active-low parity lines |
| aerr_drive_n | output | 1 | This agent's drive onto the active-low error line |
| aerr_obs_n | input | 1 | Resolved level of the shared error line |
| xact_abort | output | 1 | One-cycle pulse that aborts the current transaction |

## Verification
The bench builds the block with its default field bounds: MSB 35, LSB 3 and a group split at bit 24. These give one group of 12 lines and one of 21 lines. The even and odd group sizes mean that the all-low address tells the two groups apart, and single-bit flips in each group, as well as flips on each parity line, can be told apart from each other. The error line is looped back through a second, bench-driven agent. That brings within reach the cases of errors raised only by the other agent, overlapping errors, and errors held for several cycles, with the strap both set and clear.

// File: rtl/abp_pkg.sv
package abp_pkg;

  // Widest group the shared parity helper accepts.
  localparam int unsigned GRP_MAX = 64;

  // Per-group mismatch flags carried through the check pipeline.
  typedef struct packed {
    logic hi;
    logic lo;
  } grp_flags_t;

  // Parity level for a group of active-low lines: high when the number of
  // low lines is even. Unused positions must be padded high.
  function automatic logic ap_from_lows(input logic [GRP_MAX-1:0] lines_n);
    int unsigned lows;
    lows = 0;
    for (int i = 0; i < GRP_MAX; i++) begin
      if (!lines_n[i]) lows++;
    end
    return (lows % 2) == 0;
  endfunction

endpackage

// File: rtl/abp_grp_par.sv
module abp_grp_par #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] lines_n,
  output logic         par_n
);
  import abp_pkg::*;

  localparam int unsigned PAD = GRP_MAX - W;

  logic [GRP_MAX-1:0] padded_n;

  generate
    if (PAD > 0) begin : g_pad
      assign padded_n = {{PAD{1'b1}}, lines_n};
    end else begin : g_nopad
      assign padded_n = lines_n;
    end
  endgenerate

  assign par_n = ap_from_lows(padded_n);

endmodule

// File: rtl/abp_gen.sv
module abp_gen #(
  parameter int unsigned MSB   = 35,
  parameter int unsigned LSB   = 3,
  parameter int unsigned SPLIT = 24
) (
  input  logic [MSB:LSB] addr_n,
  output logic [1:0]     ap_n
);

  // Group 0 is the lower field, group 1 the upper field.
  for (genvar g = 0; g < 2; g++) begin : g_grp
    localparam int unsigned GL = (g == 0) ? LSB : SPLIT;
    localparam int unsigned GH = (g == 0) ? SPLIT - 1 : MSB;
    abp_grp_par #(.W(GH - GL + 1)) u_par (
      .lines_n (addr_n[GH:GL]),
      .par_n   (ap_n[g])
    );
  end

endmodule

// File: rtl/abp_chk.sv
module abp_chk #(
  parameter int unsigned MSB   = 35,
  parameter int unsigned LSB   = 3,
  parameter int unsigned SPLIT = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ads_n,
  input  logic [MSB:LSB] addr_n,
  input  logic [1:0]     ap_n,
  output logic           aerr_n
);
  import abp_pkg::*;

  logic [1:0] exp_ap_n;
  grp_flags_t grp_bad;
  logic       strobe_bad;
  grp_flags_t stage_q;
  logic       stage_err;
  logic       drive_low_q;

  abp_gen #(.MSB(MSB), .LSB(LSB), .SPLIT(SPLIT)) u_exp (
    .addr_n (addr_n),
    .ap_n   (exp_ap_n)
  );

  assign grp_bad.hi = exp_ap_n[1] ^ ap_n[1];
  assign grp_bad.lo = exp_ap_n[0] ^ ap_n[0];
  assign strobe_bad = !ads_n && (grp_bad.hi || grp_bad.lo);

  // First stage: capture the groups that failed in the strobe cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (!ads_n) begin
      stage_q <= grp_bad;
    end else begin
      stage_q <= '0;
    end
  end

  assign stage_err = stage_q.hi || stage_q.lo;

  // Second stage: drive the shared line low for one cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_low_q <= 1'b0;
    end else begin
      drive_low_q <= stage_err;
    end
  end

  assign aerr_n = !drive_low_q;

  // R3: a failing strobe cycle reaches the first stage on the next clock
  p_stage_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_bad |=> stage_err);

  // R3: a filled first stage lowers the line one clock later
  p_drive_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stage_err |=> !aerr_n);

  // R4 / R5: the line is only low two clocks after a failing strobe cycle
  p_quiet_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !aerr_n |-> $past(strobe_bad, 2));

endmodule

// File: rtl/abp_abort.sv
module abp_abort (
  input  logic clk,
  input  logic rst_n,
  input  logic strap,
  input  logic obs_n,
  output logic abort
);

  logic en_q;
  logic obs_prev_n_q;
  logic new_assert;
  logic abort_q;

  // Strap register: follows the pin only while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= strap;
  end

  assign new_assert = !obs_n && obs_prev_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obs_prev_n_q <= 1'b1;
      abort_q      <= 1'b0;
    end else begin
      obs_prev_n_q <= obs_n;
      abort_q      <= en_q && new_assert;
    end
  end

  assign abort = abort_q;

  // R6: the latched enable holds after reset release
  p_strap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(en_q));

  // R7: an abort lasts one cycle
  p_abort_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort);

  // R7: an abort follows an observed low level on the error line
  p_abort_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> $past(!obs_n));

  // R8: no abort while observation is disabled
  p_abort_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !abort);

endmodule

// File: rtl/abp_unit.sv
module abp_unit #(
  parameter int unsigned MSB   = 35,
  parameter int unsigned LSB   = 3,
  parameter int unsigned SPLIT = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_abort_en,
  input  logic [MSB:LSB] init_addr_n,
  output logic [1:0]     init_ap_n,
  input  logic           bus_ads_n,
  input  logic [MSB:LSB] bus_addr_n,
  input  logic [1:0]     bus_ap_n,
  output logic           aerr_drive_n,
  input  logic           aerr_obs_n,
  output logic           xact_abort
);

  abp_gen #(.MSB(MSB), .LSB(LSB), .SPLIT(SPLIT)) u_gen (
    .addr_n (init_addr_n),
    .ap_n   (init_ap_n)
  );

  abp_chk #(.MSB(MSB), .LSB(LSB), .SPLIT(SPLIT)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ads_n  (bus_ads_n),
    .addr_n (bus_addr_n),
    .ap_n   (bus_ap_n),
    .aerr_n (aerr_drive_n)
  );

  abp_abort u_abort (
    .clk   (clk),
    .rst_n (rst_n),
    .strap (cfg_abort_en),
    .obs_n (aerr_obs_n),
    .abort (xact_abort)
  );

endmodule

// File: tb/abp_unit_bench.sv
module abp_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg = 1'b1;
  logic [35:3] init_addr_n = '1;
  logic [1:0]  init_ap_n;
  logic        ads_n = 1'b1;
  logic [35:3] addr_n = '1;
  logic [1:0]  ap_n = 2'b11;
  logic        drive_n;
  logic        ext_n = 1'b1;
  logic        obs_n;
  logic        abort;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  bit exp_low[0:4095];
  bit exp_ab[0:4095];
  bit model_en = 1'b0;
  bit prev_low = 1'b0;

  always #2 clk = ~clk;

  assign obs_n = drive_n & ext_n;

  abp_unit u_abp_unit (
    .clk (clk), .rst_n (rst_n), .cfg_abort_en (cfg),
    .init_addr_n (init_addr_n), .init_ap_n (init_ap_n),
    .bus_ads_n (ads_n), .bus_addr_n (addr_n), .bus_ap_n (ap_n),
    .aerr_drive_n (drive_n), .aerr_obs_n (obs_n), .xact_abort (abort)
  );

  // Parity level per group: toggle once per low line, starting high.
  function automatic bit [1:0] ref_ap(input logic [35:3] a);
    bit up = 1'b1;
    bit dn = 1'b1;
    for (int i = 24; i <= 35; i++) if (a[i] == 1'b0) up = !up;
    for (int i = 3; i <= 23; i++) if (a[i] == 1'b0) dn = !dn;
    return {up, dn};
  endfunction

  task automatic check(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp_v);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Reference model and comparison, once per cycle at the falling edge.
  always @(negedge clk) begin
    if (!done) begin
      bit [1:0] g;
      bit obs_low;
      g = ref_ap(init_addr_n);
      check("R1 upper parity", int'(init_ap_n[1]), int'(g[1]));
      check("R2 lower parity", int'(init_ap_n[0]), int'(g[0]));
      if (!rst_n) begin
        check("R5 line high in reset", int'(drive_n), 1);
        check("R9 abort low in reset", int'(abort), 0);
        model_en = cfg;
        prev_low = 1'b0;
        exp_low[cyc + 1] = 1'b0;
        exp_low[cyc + 2] = 1'b0;
        exp_ab[cyc + 1]  = 1'b0;
      end else begin
        check("R3/R4/R5 error line", int'(drive_n), int'(!exp_low[cyc]));
        check("R7/R8/R9 abort", int'(abort), int'(exp_ab[cyc]));
        if (!ads_n && (ap_n != ref_ap(addr_n))) exp_low[cyc + 2] = 1'b1;
        obs_low = !obs_n;
        if (model_en && obs_low && !prev_low) exp_ab[cyc + 1] = 1'b1;
        prev_low = obs_low;
      end
    end
  end

  // One bus cycle: mode 0 correct, 1 upper-bit flip, 2 lower-bit flip,
  // 3 parity-line flip.
  task automatic bus_cycle(input bit strobe, input int mode, input bit ext_low);
    logic [35:3] a;
    bit [1:0] p;
    @(posedge clk);
    #1;
    a = {1'($urandom % 2), 32'($urandom)};
    p = ref_ap(a);
    case (mode)
      1: a[24 + ($urandom % 12)] ^= 1'b1;
      2: a[3 + ($urandom % 21)] ^= 1'b1;
      3: p[$urandom % 2] ^= 1'b1;
      default: ;
    endcase
    addr_n = a;
    ap_n = p;
    ads_n = !strobe;
    ext_n = !ext_low;
    init_addr_n = {1'($urandom % 2), 32'($urandom)};
  endtask

  task automatic do_reset(input bit strap);
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    cfg = strap;
    ads_n = 1'b1;
    ext_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++)
      bus_cycle(($urandom % 3) != 0, int'($urandom % 4), ($urandom % 9) == 0);
  endtask

  task automatic directed_gen;
    @(posedge clk);
    #1;
    init_addr_n = '1;
    #1;
    check("R1 all-high upper", int'(init_ap_n[1]), 1);
    check("R2 all-high lower", int'(init_ap_n[0]), 1);
    init_addr_n = '0;
    #1;
    check("R1 all-low upper", int'(init_ap_n[1]), 1);
    check("R2 all-low lower", int'(init_ap_n[0]), 0);
  endtask

  initial begin
    do_reset(1'b1);
    directed_gen();
    // R3 each group and the parity lines, R4 idle lines with bad parity
    for (int m = 0; m < 4; m++) begin
      bus_cycle(1'b1, m, 1'b0);
      bus_cycle(1'b0, 3, 1'b0);
      repeat (3) bus_cycle(1'b0, 0, 1'b0);
    end
    // R9 back-to-back errors, and R7 an error held low by the other agent
    bus_cycle(1'b1, 1, 1'b0);
    bus_cycle(1'b1, 2, 1'b0);
    repeat (4) bus_cycle(1'b0, 0, 1'b0);
    repeat (3) bus_cycle(1'b0, 0, 1'b1);
    repeat (3) bus_cycle(1'b0, 0, 1'b0);
    // R6 strap change after release must not disable abort
    cfg = 1'b0;
    random_run(300);
    // R8 observation disabled
    do_reset(1'b0);
    directed_gen();
    cfg = 1'b1;
    random_run(300);
    repeat (3) bus_cycle(1'b0, 0, 1'b1);
    // R6 enabled again
    do_reset(1'b1);
    random_run(300);
    repeat (4) bus_cycle(1'b0, 0, 1'b0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule